// File: doc/BRIEF.md
# Pipeline Stall and Flush Controller

This block decides, every cycle, whether the front of a five-stage in-order pipeline may advance. It looks at the two source register indices of the instruction in decode. It compares them with the destination index of the instruction one stage ahead, when that older instruction is a memory load. If the decode instruction needs a value that the load has not produced yet, the block freezes the program counter and the fetch/decode register. It also steers the decode control word to an all-zero bubble, so the load can complete before its consumer runs.

Separately, the block classifies the decode opcode into a 2-bit jump kind. It requests a flush of the fetch/decode register whenever that kind is nonzero or a branch in execute resolves as taken. A stall and a flush are computed independently. When both arise in the same cycle, both show on the outputs: the flush clears the wrongly fetched instruction while the PC stays held. The block is purely combinational, so its outputs follow its inputs within the same cycle.

Top module: `hazard_ctrl`

## Requirements
- R1: When `ex_is_load` is 1 and `ex_rd` is nonzero and equal to `dec_rs1`, `bubble_sel` is 1, `pc_we` is 0 and `ifid_we` is 0.
- R2: When `ex_is_load` is 1 and `ex_rd` is nonzero and equal to `dec_rs2`, the same stall values as in R1 appear.
- R3: When `ex_is_load` is 0, no stall is raised: `bubble_sel` is 0 and `pc_we` and `ifid_we` are 1, whatever the register indices are.
- R4: An `ex_rd` of 0 (the hard-wired zero register) never raises a stall, even when a source index is also 0.
- R5: With no load-use match, `bubble_sel` is 0 (the real control word passes) and `pc_we` and `ifid_we` are both 1.
- R6: `ifid_flush` is 1 whenever `br_taken` is 1.
- R7: `jump_kind` is 2 for opcode 7'b1101111 (direct jump-and-link), 3 for opcode 7'b1100111 (register jump-and-link) and 0 for every other opcode.
- R8: `ifid_flush` is 1 whenever `jump_kind` is nonzero, and it is 0 when `jump_kind` is 0 and `br_taken` is 0.
- R9: When a load-use stall and a flush occur in the same cycle, `ifid_flush` is 1 and `pc_we` stays 0 with `bubble_sel` at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dec_rs1 | input | 5 | First source register index of the decode instruction |
| dec_rs2 | input | 5 | Second source register index of the decode instruction |
| dec_opcode | input | 7 | Major opcode field of the decode instruction |
| ex_rd | input | 5 | Destination register index of the instruction in execute |
| ex_is_load | input | 1 | Execute instruction reads memory |
| br_taken | input | 1 | Branch in execute resolved as taken |
| bubble_sel | output | 1 | 1 selects an all-zero control word for the instruction leaving decode |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ifid_flush | output | 1 | Clear the fetch/decode register |
| jump_kind | output | 2 | Decoded jump class: 0 none, 2 direct jump, 3 register jump |

## Verification
The bench uses the default build: 5-bit register indices, two compared sources and the zero-register guard switched on. With these values the x0 corner (R4) and the case where both sources match are reachable. To make matches frequent, random register indices are drawn from a narrow range, so R1, R2 and R9 are hit many times rather than rarely. Opcodes are drawn so that the two jump encodings appear often among arbitrary values, which covers every jump kind next to stalls and taken branches.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int OPC_W = 7;

  typedef enum logic [1:0] {
    JK_NONE = 2'd0,
    JK_JAL  = 2'd2,
    JK_JALR = 2'd3
  } jump_kind_e;

  localparam logic [OPC_W-1:0] OPC_JAL  = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_JALR = 7'b1100111;
endpackage

// File: rtl/hzd_jump_decode.sv
module hzd_jump_decode
  import hzd_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output logic [1:0]       kind
);
  jump_kind_e k;

  always_comb begin
    case (opcode)
      OPC_JAL:  k = JK_JAL;
      OPC_JALR: k = JK_JALR;
      default:  k = JK_NONE;
    endcase
  end

  assign kind = k;
endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
  parameter int REG_AW   = 5,
  parameter int NSRC     = 2,
  parameter bit X0_GUARD = 1'b1
) (
  input  logic [NSRC-1:0][REG_AW-1:0] srcs,
  input  logic [REG_AW-1:0]           dst,
  input  logic                        dst_is_load,
  output logic                        stall
);
  logic [NSRC-1:0] hit;
  logic            dst_live;

  generate
    if (X0_GUARD) begin : g_guard
      assign dst_live = |dst;
    end else begin : g_noguard
      assign dst_live = 1'b1;
    end
  endgenerate

  for (genvar i = 0; i < NSRC; i++) begin : g_cmp
    assign hit[i] = (srcs[i] == dst);
  end

  assign stall = dst_is_load & dst_live & (|hit);
endmodule

// File: rtl/hzd_flush.sv
module hzd_flush (
  input  logic       br_taken,
  input  logic [1:0] kind,
  output logic       flush
);
  assign flush = br_taken | (|kind);
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hzd_pkg::*;
#(
  parameter int REG_AW   = 5,
  parameter bit X0_GUARD = 1'b1
) (
  input  logic [REG_AW-1:0] dec_rs1,
  input  logic [REG_AW-1:0] dec_rs2,
  input  logic [OPC_W-1:0]  dec_opcode,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_is_load,
  input  logic              br_taken,
  output logic              bubble_sel,
  output logic              pc_we,
  output logic              ifid_we,
  output logic              ifid_flush,
  output logic [1:0]        jump_kind
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_AW-1:0] srcs;
  logic                        stall;
  logic [1:0]                  kind;

  assign srcs[0] = dec_rs1;
  assign srcs[1] = dec_rs2;

  hzd_load_use #(
    .REG_AW  (REG_AW),
    .NSRC    (NSRC),
    .X0_GUARD(X0_GUARD)
  ) u_lu (
    .srcs       (srcs),
    .dst        (ex_rd),
    .dst_is_load(ex_is_load),
    .stall      (stall)
  );

  hzd_jump_decode u_jd (
    .opcode(dec_opcode),
    .kind  (kind)
  );

  hzd_flush u_fl (
    .br_taken(br_taken),
    .kind    (kind),
    .flush   (ifid_flush)
  );

  assign bubble_sel = stall;
  assign pc_we      = ~stall;
  assign ifid_we    = ~stall;
  assign jump_kind  = kind;
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] dec_rs1,
  input logic [REG_AW-1:0] dec_rs2,
  input logic [6:0]        dec_opcode,
  input logic [REG_AW-1:0] ex_rd,
  input logic              ex_is_load,
  input logic              br_taken,
  input logic              bubble_sel,
  input logic              pc_we,
  input logic              ifid_we,
  input logic              ifid_flush,
  input logic [1:0]        jump_kind
);
  always_comb begin
    a_r1_rs1_stall: assert (!(ex_is_load && ex_rd != '0 && ex_rd == dec_rs1) ||
                            (bubble_sel && !pc_we && !ifid_we))
      else $error("R1 stall missing");
    a_r2_rs2_stall: assert (!(ex_is_load && ex_rd != '0 && ex_rd == dec_rs2) ||
                            (bubble_sel && !pc_we && !ifid_we))
      else $error("R2 stall missing");
    a_r3_no_load: assert (ex_is_load || (!bubble_sel && pc_we && ifid_we))
      else $error("R3 stall without load");
    a_r4_zero_dst: assert (ex_rd != '0 || !bubble_sel)
      else $error("R4 stall on x0");
    a_r6_branch_flush: assert (!br_taken || ifid_flush)
      else $error("R6 flush missing");
    a_r7_jal_kind: assert (dec_opcode != 7'b1101111 || jump_kind == 2'd2)
      else $error("R7 jal kind");
    a_r7_jalr_kind: assert (dec_opcode != 7'b1100111 || jump_kind == 2'd3)
      else $error("R7 jalr kind");
    a_r8_jump_flush: assert (jump_kind == 2'd0 || ifid_flush)
      else $error("R8 flush missing");
  end
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.REG_AW(REG_AW)) u_chk (
  .dec_rs1   (dec_rs1),
  .dec_rs2   (dec_rs2),
  .dec_opcode(dec_opcode),
  .ex_rd     (ex_rd),
  .ex_is_load(ex_is_load),
  .br_taken  (br_taken),
  .bubble_sel(bubble_sel),
  .pc_we     (pc_we),
  .ifid_we   (ifid_we),
  .ifid_flush(ifid_flush),
  .jump_kind (jump_kind)
);

// File: tb/sim_hazard_ctrl.sv
`timescale 1ns/1ps
module sim_hazard_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] rs1, rs2, rd;
  logic [6:0] opc;
  logic       ld, bt;
  logic       bubble_sel, pc_we, ifid_we, ifid_flush;
  logic [1:0] jump_kind;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  hazard_ctrl u0 (
    .dec_rs1(rs1), .dec_rs2(rs2), .dec_opcode(opc), .ex_rd(rd),
    .ex_is_load(ld), .br_taken(bt), .bubble_sel(bubble_sel), .pc_we(pc_we),
    .ifid_we(ifid_we), .ifid_flush(ifid_flush), .jump_kind(jump_kind)
  );

  function automatic logic [1:0] ref_kind(input logic [6:0] o);
    if (o == 7'b1101111) return 2'd2;
    if (o == 7'b1100111) return 2'd3;
    return 2'd0;
  endfunction

  // packed: {bubble_sel, pc_we, ifid_we, ifid_flush, jump_kind}
  function automatic logic [5:0] ref_out(input logic [4:0] a, input logic [4:0] b,
                                         input logic [4:0] d, input logic l,
                                         input logic t, input logic [6:0] o);
    logic s;
    logic [1:0] k;
    s = l && d != 5'd0 && (d == a || d == b);
    k = ref_kind(o);
    return {s, !s, !s, t || k != 2'd0, k};
  endfunction

  task automatic apply(input logic [4:0] a, input logic [4:0] b, input logic [4:0] d,
                       input logic l, input logic t, input logic [6:0] o,
                       input string tag);
    logic [5:0] exp, act;
    @(posedge clk);
    rs1 = a; rs2 = b; rd = d; ld = l; bt = t; opc = o;
    @(negedge clk);
    exp = ref_out(a, b, d, l, t, o);
    act = {bubble_sel, pc_we, ifid_we, ifid_flush, jump_kind};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs %b expected %b (rs1=%0d rs2=%0d rd=%0d ld=%0d bt=%0d op=%b)",
               tag, act, exp, a, b, d, l, t, o);
    end
  endtask

  function automatic string tag_of(input logic [4:0] a, input logic [4:0] b,
                                   input logic [4:0] d, input logic l,
                                   input logic t, input logic [6:0] o);
    logic s;
    s = l && d != 5'd0 && (d == a || d == b);
    if (s && (t || ref_kind(o) != 2'd0)) return "R9";
    if (s && d == a) return "R1";
    if (s) return "R2";
    if (l && d == 5'd0) return "R4";
    if (!l) return "R3";
    if (ref_kind(o) != 2'd0) return "R8";
    if (t) return "R6";
    return "R5";
  endfunction

  initial begin
    void'($urandom(32'd1234));
    rs1 = '0; rs2 = '0; rd = '0; ld = 1'b0; bt = 1'b0; opc = 7'b0010011;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // idle state after reset
    apply(5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 7'b0010011, "R5");
    // directed corners
    apply(5'd7, 5'd3, 5'd7, 1'b1, 1'b0, 7'b0110011, "R1");
    apply(5'd2, 5'd9, 5'd9, 1'b1, 1'b0, 7'b0100011, "R2");
    apply(5'd4, 5'd4, 5'd4, 1'b1, 1'b0, 7'b0110011, "R2");
    apply(5'd7, 5'd7, 5'd7, 1'b0, 1'b0, 7'b0110011, "R3");
    apply(5'd0, 5'd0, 5'd0, 1'b1, 1'b0, 7'b0110011, "R4");
    apply(5'd1, 5'd2, 5'd3, 1'b1, 1'b0, 7'b0110011, "R5");
    apply(5'd1, 5'd2, 5'd3, 1'b0, 1'b1, 7'b1100011, "R6");
    apply(5'd0, 5'd0, 5'd5, 1'b0, 1'b0, 7'b1101111, "R7");
    apply(5'd6, 5'd0, 5'd5, 1'b0, 1'b0, 7'b1100111, "R7");
    apply(5'd6, 5'd0, 5'd5, 1'b0, 1'b0, 7'b1101011, "R8");
    apply(5'd6, 5'd0, 5'd6, 1'b1, 1'b1, 7'b0110011, "R9");
    apply(5'd6, 5'd0, 5'd6, 1'b1, 1'b0, 7'b1100111, "R9");
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] a, b, d;
      logic [6:0] o;
      logic l, t;
      int sel;
      a = 5'($urandom_range(0, 3));
      b = 5'($urandom_range(0, 3));
      d = 5'($urandom_range(0, 3));
      if (($urandom & 7) == 0) a = 5'($urandom);
      l = 1'($urandom);
      t = (($urandom & 3) == 0);
      sel = int'($urandom_range(0, 3));
      o = (sel == 0) ? 7'b1101111 : (sel == 1) ? 7'b1100111 : 7'($urandom);
      apply(a, b, d, l, t, o, tag_of(a, b, d, l, t, o));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule